// File: doc/BRIEF.md
# Rotating-Crossbar Lookup Request Dispatcher

This block spreads route-lookup requests over N memory ports so that no single memory port carries a disproportionate share. Each request names two root memory blocks, either of which can serve it. Time is divided into slots of N clock cycles. A request that arrives in cycle c of a slot goes to input buffer c. Inside that buffer it joins the per-destination queue of whichever of its two root blocks currently has fewer requests waiting.

A cyclic-shift rotator connects every input buffer to exactly one output buffer during each slot. In the middle cycle of the slot, the oldest request in each connected queue moves into the FIFO of its output buffer. The mapping then shifts by one position at the end of the slot. Each output FIFO presents requests to its memory port through a valid/ready pair and releases at most one request per slot, which matches one memory access per slot.

N is a power of two. The full flags are taken before any removal that happens in the same cycle, so a queue that is draining in that cycle still reads as full.

Top module: `rotor_dispatch`

## Requirements
- R1: After reset every out_valid bit is 0 and in_ready is 1. The first cycle after reset release is cycle 0 of slot 0.
- R2: A request accepted in cycle c of a slot (c = cycles since reset mod N) is placed in input buffer c.
- R3: Within its input buffer, a request joins the queue for in_root_a or for in_root_b, whichever holds fewer entries. On equal counts it joins the queue of the numerically lower root index.
- R4: During slot t (t = slots since reset mod N), input buffer i is connected to output buffer (i + t) mod N. The mapping advances once, at the end of each slot.
- R5: The head request of each connected non-empty queue moves on the clock edge that ends cycle N/2 of the slot. It is visible at its output port in cycle N/2 + 1.
- R6: Each output port releases at most one request per slot, at a valid/ready handshake. While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.
- R7: in_ready is low when both candidate queues of the current input buffer are full. A source that keeps the request valid has it accepted in a later cycle, and it is not lost.
- R8: When an output FIFO is full, the transfer into it is skipped for that slot and the head request stays in its queue.
- R9: Every accepted request leaves exactly once, on a port equal to one of its two root indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The offered request is taken on this edge |
| in_data | input | DW | Request payload |
| in_root_a | input | log2(N) | First candidate root block |
| in_root_b | input | log2(N) | Second candidate root block |
| out_valid | output | N | A request is available on each memory port |
| out_ready | input | N | Each memory port takes its request |
| out_data | output | N*DW | Payloads, port j in bits j*DW +: DW |

## Verification
The bench builds the block with N = 4, queue depth 4, output FIFO depth 8 and 8-bit payloads. With these values a full rotation takes 16 cycles, so every input-to-output mapping appears within a short directed run. One queue fills after five slots of traffic aimed at a single root. All storage that leads to one port is saturated by 24 requests, which exercises both the input backpressure and the stalled transfer into a full FIFO. A random phase with mixed root pairs and irregular out_ready then checks conservation and the once-per-slot release limit.

// File: rtl/rotor_dispatch.sv
module rotor_dispatch #(
  parameter int N  = 4,
  parameter int VD = 4,
  parameter int OD = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [IW-1:0] in_root_a,
  input  logic [IW-1:0] in_root_b,
  output logic [N-1:0]  out_valid,
  input  logic [N-1:0]  out_ready,
  output logic [N*DW-1:0] out_data
);
  localparam int VW  = $clog2(VD);
  localparam int OW  = $clog2(OD);
  localparam int QN  = N * N;
  localparam int QW  = 2 * IW;
  localparam int MID = N / 2;

  logic [IW-1:0] cyc, slot;
  logic          last_cyc;

  logic [VW:0]   vcnt [QN];
  logic [VW-1:0] vrd  [QN];
  logic [VW-1:0] vwr  [QN];
  logic [DW-1:0] vmem [QN][VD];
  logic [QN-1:0] vpush, vpop;

  logic [OW:0]   ocnt [N];
  logic [OW-1:0] ord  [N];
  logic [OW-1:0] owr  [N];
  logic [DW-1:0] omem [N][OD];
  logic [N-1:0]  sent, mv, oin, opop;
  logic [DW-1:0] odin [N];
  logic [IW-1:0] dst  [N];
  logic [IW-1:0] src  [N];

  logic [QW-1:0] qa, qb, qsel;
  logic          pick_b, push;

  assign last_cyc = cyc == IW'(N - 1);

  assign qa     = {cyc, in_root_a};
  assign qb     = {cyc, in_root_b};
  assign pick_b = (vcnt[qb] < vcnt[qa]) || ((vcnt[qb] == vcnt[qa]) && (in_root_b < in_root_a));
  assign qsel   = pick_b ? qb : qa;
  assign in_ready = vcnt[qsel] != (VW+1)'(VD);
  assign push   = in_valid && in_ready;

  for (genvar i = 0; i < N; i++) begin : g_port
    logic [QW-1:0] qout, qin;
    assign dst[i]  = IW'(i) + slot;
    assign src[i]  = IW'(i) - slot;
    assign qout    = {IW'(i), dst[i]};
    assign qin     = {src[i], IW'(i)};
    assign mv[i]   = (cyc == IW'(MID)) && (vcnt[qout] != '0) && (ocnt[dst[i]] != (OW+1)'(OD));
    assign oin[i]  = mv[src[i]];
    assign odin[i] = vmem[qin][vrd[qin]];
    assign out_valid[i] = (ocnt[i] != '0) && !sent[i];
    assign out_data[i*DW +: DW] = omem[i][ord[i]];
    assign opop[i] = out_valid[i] && out_ready[i];
  end

  for (genvar q = 0; q < QN; q++) begin : g_voq
    assign vpush[q] = push && (qsel == QW'(q));
    assign vpop[q]  = mv[q / N] && (dst[q / N] == IW'(q % N));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      slot <= '0;
      sent <= '0;
      for (int q = 0; q < QN; q++) begin
        vcnt[q] <= '0;
        vrd[q]  <= '0;
        vwr[q]  <= '0;
      end
      for (int j = 0; j < N; j++) begin
        ocnt[j] <= '0;
        ord[j]  <= '0;
        owr[j]  <= '0;
      end
    end else begin
      cyc  <= last_cyc ? '0 : cyc + IW'(1);
      slot <= last_cyc ? slot + IW'(1) : slot;
      sent <= last_cyc ? '0 : (sent | opop);
      for (int q = 0; q < QN; q++) begin
        if (vpush[q]) vwr[q] <= (vwr[q] == VW'(VD - 1)) ? '0 : vwr[q] + VW'(1);
        if (vpop[q])  vrd[q] <= (vrd[q] == VW'(VD - 1)) ? '0 : vrd[q] + VW'(1);
        vcnt[q] <= vcnt[q] + (VW+1)'(vpush[q]) - (VW+1)'(vpop[q]);
      end
      for (int j = 0; j < N; j++) begin
        if (oin[j])  owr[j] <= (owr[j] == OW'(OD - 1)) ? '0 : owr[j] + OW'(1);
        if (opop[j]) ord[j] <= (ord[j] == OW'(OD - 1)) ? '0 : ord[j] + OW'(1);
        ocnt[j] <= ocnt[j] + (OW+1)'(oin[j]) - (OW+1)'(opop[j]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < QN; q++)
      if (vpush[q]) vmem[q][vwr[q]] <= in_data;
    for (int j = 0; j < N; j++)
      if (oin[j]) omem[j][owr[j]] <= odin[j];
  end
endmodule

// File: rtl/rotor_dispatch_chk.sv
module rotor_dispatch_chk #(
  parameter int N  = 4,
  parameter int VD = 4,
  parameter int OD = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [N-1:0]    out_valid,
  input logic [N-1:0]    out_ready,
  input logic [N*DW-1:0] out_data
);
  localparam int MID = N / 2;
  localparam int CAP = N * N * VD + N * OD;

  logic [IW-1:0] ccyc;
  logic [N-1:0]  took;
  logic [15:0]   outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccyc  <= '0;
      took  <= '0;
      outst <= '0;
    end else begin
      ccyc  <= ccyc + IW'(1);
      took  <= (ccyc == IW'(N - 1)) ? '0 : (took | (out_valid & out_ready));
      outst <= outst + 16'(in_valid && in_ready) - 16'($countones(out_valid & out_ready));
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    // R6
    rate_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && out_ready[j]) |-> !took[j]);
    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && !out_ready[j]) |=> (out_valid[j] && $stable(out_data[j*DW +: DW])));
    // R5
    rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid[j]) |-> ((ccyc == IW'((MID + 1) % N)) || (ccyc == '0)));
  end

  // R9
  occupancy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= 16'(CAP));
endmodule

bind rotor_dispatch rotor_dispatch_chk #(.N(N), .VD(VD), .OD(OD), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_rotor_dispatch.sv
module test_rotor_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [DW-1:0] in_data = 0;
  logic [1:0]    in_root_a = 0, in_root_b = 0;
  logic [N-1:0]  out_valid;
  logic [N-1:0]  out_ready = '1;
  logic [N*DW-1:0] out_data;

  int checks = 0, errors = 0, k = 0;
  int acc [256];
  int del [256];
  int ra [256];
  int rb [256];
  int last_slot [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rotor_dispatch i_rotor_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_root_a(in_root_a), .in_root_b(in_root_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk) if (!rst_n) k <= 0; else k <= k + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (in_valid && in_ready) begin
        acc[in_data]++;
        ra[in_data] = in_root_a;
        rb[in_data] = in_root_b;
      end
      for (int j = 0; j < N; j++) begin
        if (out_valid[j] && out_ready[j]) begin
          int t;
          t = out_data[j*DW +: DW];
          chk(del[t] < acc[t] && (j == ra[t] || j == rb[t]), "R9",
              $sformatf("tag %0d on port %0d (count, port)", t, j), del[t] + 1, acc[t]);
          del[t]++;
          chk(last_slot[j] != k / N, "R6", $sformatf("releases on port %0d in slot %0d", j, k / N), 2, 1);
          last_slot[j] = k / N;
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    in_valid = 0; in_data = 0; in_root_a = 0; in_root_b = 0; out_ready = '1;
    for (int t = 0; t < 256; t++) begin acc[t] = 0; del[t] = 0; ra[t] = 0; rb[t] = 0; end
    for (int j = 0; j < N; j++) last_slot[j] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_k(int n);
    while (k < n) @(negedge clk);
  endtask

  task automatic check_all(string what);
    int bad = 0;
    for (int t = 0; t < 256; t++) if (del[t] != acc[t]) bad++;
    chk(bad == 0, "R9", {what, " tags delivered a different number of times than accepted"}, bad, 0);
  endtask

  task automatic put(int d, int a, int b);
    in_valid = 1; in_data = DW'(d); in_root_a = 2'(a); in_root_b = 2'(b);
  endtask

  task automatic t_reset_and_path();
    do_reset();
    #1;
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    put(8'hA1, 2, 1);
    @(negedge clk);
    put(8'hA2, 2, 3);
    @(negedge clk);
    in_valid = 0;
    wait_k(6); #1;
    chk(out_valid == 0, "R5", "out_valid before mid-slot transfer", out_valid, 0);
    wait_k(7); #1;
    chk(out_valid == 4'b0110, "R4", "ports valid after slot 1 transfer", out_valid, 4'b0110);
    chk(out_data[1*DW +: DW] == 8'hA1, "R3", "tie goes to lower root, port 1 data", out_data[1*DW +: DW], 8'hA1);
    chk(out_data[2*DW +: DW] == 8'hA2, "R2", "cycle 1 request via buffer 1 on port 2", out_data[2*DW +: DW], 8'hA2);
    wait_k(8); #1;
    chk(out_valid == 0, "R6", "ports empty after handshake", out_valid, 0);
    wait_k(40);
    check_all("path");
  endtask

  task automatic t_shorter_queue();
    do_reset();
    put(8'hB1, 1, 2);
    @(negedge clk);
    in_valid = 0;
    wait_k(4);
    put(8'hB2, 3, 1);
    @(negedge clk);
    in_valid = 0;
    wait_k(7); #1;
    chk(out_valid == 4'b0010, "R3", "only port 1 valid in slot 1", out_valid, 4'b0010);
    chk(out_data[1*DW +: DW] == 8'hB1, "R3", "port 1 data", out_data[1*DW +: DW], 8'hB1);
    wait_k(14); #1;
    chk(out_valid[3] == 0, "R4", "port 3 before slot 3 transfer", out_valid[3], 0);
    wait_k(15); #1;
    chk(out_valid[3] == 1 && out_data[3*DW +: DW] == 8'hB2, "R3",
        "emptier queue chosen, port 3 data", out_data[3*DW +: DW], 8'hB2);
    wait_k(40);
    check_all("shorter");
  endtask

  task automatic t_queue_full();
    do_reset();
    for (int s = 0; s < 5; s++) begin
      wait_k(s * N);
      put(s, 1, 1);
      @(negedge clk);
      in_valid = 0;
    end
    wait_k(20);
    put(5, 1, 1);
    #1;
    chk(in_ready == 0, "R7", "in_ready with both candidates full", in_ready, 0);
    @(negedge clk);
    #1;
    chk(in_ready == 1, "R7", "held request accepted by next buffer", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    wait_k(120);
    chk(acc[5] == 1 && del[5] == 1, "R7", "held request delivered once", del[5], 1);
    check_all("queue full");
  endtask

  task automatic t_fifo_full();
    int sent_n = 0;
    int tries = 0;
    do_reset();
    out_ready = '0;
    while (sent_n < 24 && tries < 400) begin
      put(sent_n, 1, 1);
      #1;
      if (in_ready) sent_n++;
      tries++;
      @(negedge clk);
    end
    in_valid = 0;
    chk(sent_n == 24, "R8", "requests stored toward one blocked port", sent_n, 24);
    repeat (64) @(negedge clk);
    #1;
    chk(out_valid == 4'b0010, "R8", "only blocked port valid", out_valid, 4'b0010);
    for (int c = 0; c < N; c++) begin
      put(200, 1, 1);
      #1;
      chk(in_ready == 0, "R7", $sformatf("in_ready while path saturated, cycle %0d", c), in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0;
    out_ready = '1;
    repeat (160) @(negedge clk);
    chk(del[23] == 1 && del[0] == 1, "R8", "stalled requests released", del[23] + del[0], 2);
    check_all("fifo full");
  endtask

  task automatic t_random();
    logic [15:0] r = 16'hACE1;
    int tag = 0;
    bit pend = 0;
    do_reset();
    for (int c = 0; c < 600; c++) begin
      r = r ^ (r << 7);
      r = r ^ (r >> 9);
      r = r ^ (r << 8);
      if (!pend && r[1:0] != 0 && tag < 200) begin
        pend = 1;
        put(tag, r[3:2], r[3:2] ^ (2'd1 + 2'(r[5:4] % 3)));
      end
      in_valid = pend;
      out_ready = r[11:8] | r[15:12];
      #1;
      if (pend && in_ready) begin
        pend = 0;
        tag++;
      end
      @(negedge clk);
    end
    in_valid = 0;
    out_ready = '1;
    repeat (300) @(negedge clk);
    chk(tag > 100, "R9", "random requests accepted", tag, 101);
    check_all("random");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_and_path();
    t_shorter_queue();
    t_queue_full();
    t_fifo_full();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule